// File: doc/BRIEF.md
# Video Packet Length Checker

This block watches a valid/ready video packet stream and checks that each video data packet carries exactly as many pixel beats as the most recent control packet announced. A control packet supplies a frame width and a frame height. The checker multiplies them to get the expected pixel count, then counts the pixel beats of each following data packet against that figure. The checker only observes the stream. Every stream signal enters it as an input, and it drives nothing back onto the stream, so it can sit on any link without changing the traffic.

When it finds a violation, the block raises a one-cycle error pulse. This pulse is meant to drive the trigger input of a trace capture or an on-chip logic analyser. At the same time the block records the kind of error in a sticky code register, which keeps every error seen since reset. Packets are framed only by an end-of-packet flag: the beat that follows an end-of-packet beat (or the first beat after reset) is the header of a new packet.

Top module: `vpc_checker`

## Requirements
- R1: After a synchronous active-low reset, `err_pulse` and `err_code` are zero and no expected size is known.
- R2: The first transferred beat after reset, or after an end-of-packet beat, is a header. Its bits [3:0] give the packet kind: 4'h0 is video data, 4'hF is control, and any other value is a packet that the checker ignores.
- R3: Only cycles with both `s_valid` and `s_ready` high count as beats. Cycles without a transfer have no effect, whatever the data and eop values are.
- R4: In a control packet, payload beat 1 carries the width in bits [15:0] and payload beat 2 carries the height in bits [15:0]. Any further payload beats are ignored. At its end-of-packet, a complete control packet sets the expected size to width times height.
- R5: A control packet that ends with fewer than two payload beats sets `err_code` bit 3 (malformed control) and leaves the expected size unchanged.
- R6: A data packet whose header arrives while no expected size is known sets `err_code` bit 2 (no prior control). Its length is not checked.
- R7: A data packet that carries more payload beats than expected sets `err_code` bit 1 (too long). This happens on the first excess beat only, once per packet.
- R8: A data packet that ends with fewer payload beats than expected sets `err_code` bit 0 (too short). The check is made at its end-of-packet beat, and a header-only packet counts zero pixels.
- R9: `err_pulse` is high for exactly the one cycle after each offending beat. `err_code` ORs in each new error and is cleared only by reset.
- R10: When several control packets come before a data packet, the last complete one sets the expected size.
- R11: A data packet whose length matches the expected size raises no error. This includes an expected size of zero with a header-only packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Stream valid, observed only |
| s_ready | input | 1 | Stream ready, observed only |
| s_data | input | DATA_W | Stream data beat |
| s_eop | input | 1 | Last beat of a packet |
| err_pulse | output | 1 | One-cycle pulse per detected error |
| err_code | output | 4 | Sticky error bits: 0 short, 1 long, 2 no control, 3 malformed control |

## Verification
If the header flag is wrong, a packet's kind is misread. Every payload beat is then treated as a fresh header, and this shows up as spurious no-control or missing too-long pulses within a beat or two. A wrong beat counter or a wrong stored size shows up at the ports on the first excess beat of a data packet, or on its end-of-packet beat, as a pulse one cycle late, early or missing. A control packet that was lost or wrongly accepted only becomes visible when the next data packet is checked. The bench therefore follows every control packet with data packets whose lengths sit exactly on, one below and one above the announced size, and compares the pulse and code on every cycle.

// File: rtl/vpc_pkg.sv
// Shared constants for the video packet length checker.
// Assumes packet kinds are coded in the low nibble of a header beat.
package vpc_pkg;
    localparam int          KIND_W     = 4;
    localparam logic [3:0]  KIND_DATA  = 4'h0;
    localparam logic [3:0]  KIND_CTRL  = 4'hF;
    localparam int          ERR_N      = 4;

    // Error vector, least significant field is bit 0 of err_code
    typedef struct packed {
        logic bad_ctrl;   // bit 3
        logic no_ctrl;    // bit 2
        logic too_long;   // bit 1
        logic too_short;  // bit 0
    } err_vec_t;
endpackage

// File: rtl/vpc_beat_track.sv
// Tracks packet framing: marks header beats, remembers the packet kind
// and counts payload beats (saturating). Assumes beat = valid & ready.
module vpc_beat_track #(
    parameter int CNT_W = 33
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     beat,
    input  logic                     eop,
    input  logic [vpc_pkg::KIND_W-1:0] hdr_kind,
    output logic                     hdr_now,
    output logic [vpc_pkg::KIND_W-1:0] cur_kind,
    output logic [CNT_W-1:0]         pay_idx
);
    logic                         in_pkt;
    logic [vpc_pkg::KIND_W-1:0]   kind_q;
    logic [CNT_W-1:0]             pay_q;

    // Framing state: inside a packet or waiting for its header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
            kind_q <= '0;
            pay_q  <= '0;
        end else if (beat) begin
            in_pkt <= !eop;
            if (!in_pkt) begin
                kind_q <= hdr_kind;
                pay_q  <= '0;
            end else if (pay_q != {CNT_W{1'b1}}) begin
                pay_q <= pay_q + 1'b1;
            end
        end
    end

    // Present the current beat's role to the checkers
    always_comb begin
        hdr_now  = !in_pkt;
        cur_kind = in_pkt ? kind_q : hdr_kind;
        pay_idx  = pay_q;
    end

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> ($stable(in_pkt) && $stable(pay_q)));
endmodule

// File: rtl/vpc_dim_reg.sv
// Captures width and height from control packets and holds the expected
// pixel count. Only a control packet with two or more payload beats
// updates the size; shorter ones are reported as malformed.
module vpc_dim_reg #(
    parameter int DIM_W = 16,
    parameter int CNT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             eop,
    input  logic             hdr_now,
    input  logic             is_ctrl,
    input  logic [CNT_W-1:0] pay_idx,
    input  logic [DIM_W-1:0] field,
    output logic             exp_known,
    output logic [CNT_W-1:0] exp_len,
    output logic             bad_ctrl
);
    localparam int PAD = CNT_W - DIM_W;

    logic [DIM_W-1:0] wid_q, hgt_q, hgt_use;
    logic             known_q;
    logic [CNT_W-1:0] len_q;
    logic             ctl_pay, good_end;

    // Classify the current control beat
    always_comb begin
        ctl_pay  = beat && is_ctrl && !hdr_now;
        good_end = ctl_pay && eop && (pay_idx != '0);
        bad_ctrl = beat && is_ctrl && eop && (hdr_now || pay_idx == '0);
        hgt_use  = (pay_idx == CNT_W'(1)) ? field : hgt_q;
    end

    // Field capture and expected size update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wid_q   <= '0;
            hgt_q   <= '0;
            known_q <= 1'b0;
            len_q   <= '0;
        end else begin
            if (ctl_pay && pay_idx == '0)        wid_q <= field;
            if (ctl_pay && pay_idx == CNT_W'(1)) hgt_q <= field;
            if (good_end) begin
                known_q <= 1'b1;
                len_q   <= {{PAD{1'b0}}, wid_q} * {{PAD{1'b0}}, hgt_use};
            end
        end
    end

    assign exp_known = known_q;
    assign exp_len   = len_q;

    a_r5_bad_keeps_size: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ctrl |=> ($stable(len_q) && $stable(known_q)));
endmodule

// File: rtl/vpc_len_check.sv
// Compares the payload length of video data packets with the expected
// size. Flags a missing size at the header, excess on the first extra
// beat (once per packet) and shortfall at end-of-packet.
module vpc_len_check #(
    parameter int CNT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             eop,
    input  logic             hdr_now,
    input  logic             is_data,
    input  logic [CNT_W-1:0] pay_idx,
    input  logic             exp_known,
    input  logic [CNT_W-1:0] exp_len,
    output logic             too_short,
    output logic             too_long,
    output logic             no_ctrl
);
    logic             long_seen;
    logic [CNT_W:0]   got;

    // Error events for the current beat
    always_comb begin
        got       = hdr_now ? '0 : ({1'b0, pay_idx} + 1'b1);
        no_ctrl   = beat && is_data && hdr_now && !exp_known;
        too_long  = beat && is_data && !hdr_now && exp_known && !long_seen
                    && (pay_idx >= exp_len);
        too_short = beat && is_data && eop && exp_known && (got < {1'b0, exp_len});
    end

    // Remember that this packet has already been reported as too long
    always_ff @(posedge clk) begin
        if (!rst_n)                  long_seen <= 1'b0;
        else if (beat && hdr_now)    long_seen <= 1'b0;
        else if (too_long)           long_seen <= 1'b1;
    end

    a_r7_long_once: assert property (@(posedge clk) disable iff (!rst_n)
        too_long |=> !too_long);
    a_r9_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({too_short, too_long, no_ctrl}));
endmodule

// File: rtl/vpc_checker.sv
// Top level of the passive video packet length checker. Observes a
// valid/ready stream, raises err_pulse the cycle after a violation and
// accumulates sticky error bits. Assumes DATA_W >= DIM_W.
module vpc_checker #(
    parameter int DATA_W = 24,
    parameter int DIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_eop,
    output logic              err_pulse,
    output logic [3:0]        err_code
);
    import vpc_pkg::*;

    localparam int CNT_W = 2 * DIM_W + 1;

    logic              beat, hdr_now, exp_known;
    logic [KIND_W-1:0] cur_kind;
    logic [CNT_W-1:0]  pay_idx, exp_len;
    err_vec_t          ev;

    assign beat = s_valid && s_ready;

    vpc_beat_track #(.CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .beat(beat), .eop(s_eop),
        .hdr_kind(s_data[KIND_W-1:0]), .hdr_now(hdr_now),
        .cur_kind(cur_kind), .pay_idx(pay_idx)
    );

    vpc_dim_reg #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_dim (
        .clk(clk), .rst_n(rst_n), .beat(beat), .eop(s_eop),
        .hdr_now(hdr_now), .is_ctrl(cur_kind == KIND_CTRL),
        .pay_idx(pay_idx), .field(s_data[DIM_W-1:0]),
        .exp_known(exp_known), .exp_len(exp_len), .bad_ctrl(ev.bad_ctrl)
    );

    vpc_len_check #(.CNT_W(CNT_W)) u_len (
        .clk(clk), .rst_n(rst_n), .beat(beat), .eop(s_eop),
        .hdr_now(hdr_now), .is_data(cur_kind == KIND_DATA),
        .pay_idx(pay_idx), .exp_known(exp_known), .exp_len(exp_len),
        .too_short(ev.too_short), .too_long(ev.too_long), .no_ctrl(ev.no_ctrl)
    );

    // Register the trigger pulse and accumulate sticky error bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_code  <= '0;
        end else begin
            err_pulse <= |ev;
            err_code  <= err_code | ev;
        end
    end

    a_r9_pulse_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_code != 4'b0));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_code & $past(err_code)) == $past(err_code)));
endmodule

// File: tb/tb_vpc_checker.sv
// Self-checking bench with a behavioural reference model, compared every cycle.
module tb_vpc_checker;
    localparam int DATA_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_valid = 1'b0;
    logic              s_ready = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_eop = 1'b0;
    logic              err_pulse;
    logic [3:0]        err_code;

    int    compared = 0;
    int    mismatched = 0;
    string phase = "R1 reset";

    vpc_checker #(.DATA_W(DATA_W), .DIM_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_eop(s_eop), .err_pulse(err_pulse), .err_code(err_code)
    );

    always #5 clk = ~clk;

    // Reference model state
    bit       m_in_pkt;
    int       m_kind;
    longint   m_cnt;
    bit       m_known;
    longint   m_exp;
    longint   m_w, m_h;
    bit       m_long;
    bit       m_pulse;
    bit [3:0] m_code;

    always @(posedge clk) begin
        bit [3:0] ev;
        ev = 4'b0;
        if (!rst_n) begin
            m_in_pkt = 0; m_kind = 0; m_cnt = 0; m_known = 0; m_exp = 0;
            m_w = 0; m_h = 0; m_long = 0; m_pulse = 0; m_code = 0;
        end else begin
            if (s_valid && s_ready) begin
                if (!m_in_pkt) begin
                    m_kind = int'(s_data[3:0]);
                    m_cnt = 0;
                    m_long = 0;
                    if (m_kind == 0 && !m_known) ev[2] = 1;
                    if (s_eop) begin
                        if (m_kind == 0 && m_known && m_exp > 0) ev[0] = 1;
                        if (m_kind == 15) ev[3] = 1;
                    end
                    m_in_pkt = !s_eop;
                end else begin
                    m_cnt++;
                    if (m_kind == 15 && m_cnt == 1) m_w = longint'(s_data[15:0]);
                    if (m_kind == 15 && m_cnt == 2) m_h = longint'(s_data[15:0]);
                    if (m_kind == 0 && m_known && m_cnt > m_exp && !m_long) begin
                        ev[1] = 1; m_long = 1;
                    end
                    if (s_eop) begin
                        if (m_kind == 0 && m_known && m_cnt < m_exp) ev[0] = 1;
                        if (m_kind == 15) begin
                            if (m_cnt < 2) ev[3] = 1;
                            else begin m_known = 1; m_exp = m_w * m_h; end
                        end
                        m_in_pkt = 0;
                    end
                end
            end
            m_pulse = |ev;
            m_code = m_code | ev;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        compared++;
        if (err_pulse !== m_pulse || err_code !== m_code) begin
            mismatched++;
            $display("FAIL [%s] R9 cycle compare: pulse=%0b code=%b expected pulse=%0b code=%b",
                     phase, err_pulse, err_code, m_pulse, m_code);
        end
    end

    task automatic send_beat(input logic [DATA_W-1:0] d, input logic e);
        bit acc;
        if ($urandom % 4 == 0) begin
            s_valid = 1'b0; s_ready = 1'b1; s_eop = 1'b1; s_data = DATA_W'($urandom);
            @(negedge clk);
        end
        s_valid = 1'b1; s_data = d; s_eop = e;
        do begin
            acc = ($urandom % 3 != 0);
            s_ready = acc;
            @(negedge clk);
        end while (!acc);
        s_valid = 1'b0; s_eop = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] hdr(input logic [3:0] k);
        return {DATA_W'($urandom) >> 4, k};
    endfunction

    task automatic send_ctrl(input int w, input int h, input int npay);
        send_beat(hdr(4'hF), npay == 0);
        for (int i = 0; i < npay; i++) begin
            logic [DATA_W-1:0] d;
            d = DATA_W'($urandom);
            if (i == 0) d[15:0] = 16'(w);
            if (i == 1) d[15:0] = 16'(h);
            send_beat(d, i == npay - 1);
        end
    endtask

    task automatic send_pkt(input logic [3:0] k, input int n);
        send_beat(hdr(k), n == 0);
        for (int i = 0; i < n; i++) send_beat(DATA_W'($urandom), i == n - 1);
    endtask

    task automatic check_code(input logic [3:0] exp, input string tag);
        @(negedge clk);
        compared++;
        if (err_code !== exp) begin
            mismatched++;
            $display("FAIL %s: err_code=%b expected %b", tag, err_code, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; s_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        phase = "R1";
        compared++;
        if (err_pulse !== 1'b0 || err_code !== 4'b0) begin
            mismatched++;
            $display("FAIL R1 reset: pulse=%0b code=%b expected 0 0000", err_pulse, err_code);
        end
        // R6: data with no control
        phase = "R6"; send_pkt(4'h0, 3); check_code(4'b0100, "R6 no prior control");
        // R4 R3 R11: exact length with stalls
        do_reset(); phase = "R4";
        send_ctrl(3, 2, 2); send_pkt(4'h0, 6); check_code(4'b0000, "R4 R3 R11 exact length");
        // R7: too long by one, then far too long
        phase = "R7"; send_pkt(4'h0, 7); check_code(4'b0010, "R7 one excess beat");
        send_pkt(4'h0, 10); check_code(4'b0010, "R7 many excess beats");
        // R8: too short
        do_reset(); phase = "R8";
        send_ctrl(2, 2, 2); send_pkt(4'h0, 3); check_code(4'b0001, "R8 short packet");
        send_pkt(4'h0, 0); check_code(4'b0001, "R8 header only short");
        // R5: malformed control leaves size unknown
        do_reset(); phase = "R5";
        send_ctrl(5, 5, 1); check_code(4'b1000, "R5 malformed control");
        send_pkt(4'h0, 25); check_code(4'b1100, "R5 size still unknown");
        send_ctrl(1, 1, 0); check_code(4'b1100, "R5 header only control");
        // R10: last control wins
        do_reset(); phase = "R10";
        send_ctrl(4, 1, 2); send_ctrl(2, 1, 2); send_pkt(4'h0, 2);
        check_code(4'b0000, "R10 latest size used");
        send_pkt(4'h0, 4); check_code(4'b0010, "R10 older size not used");
        // R5 R10: malformed after good keeps good size
        do_reset(); phase = "R5b";
        send_ctrl(3, 1, 2); send_ctrl(9, 9, 1); send_pkt(4'h0, 3);
        check_code(4'b1000, "R5 earlier size kept");
        // R2 R11: ignored kinds, zero size, extra control beats
        do_reset(); phase = "R2";
        send_pkt(4'h5, 3); send_pkt(4'h1, 0); check_code(4'b0000, "R2 other kinds ignored");
        send_ctrl(0, 5, 2); send_pkt(4'h0, 0); check_code(4'b0000, "R11 zero size header only");
        send_ctrl(1, 1, 4); send_pkt(4'h0, 1); check_code(4'b0000, "R4 extra control beats");
        send_pkt(4'h0, 2); check_code(4'b0010, "R4 extra beats not size");
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule